// File: doc/BRIEF.md
# Byte-lane parity checker and generator

This block sits behind one 36-bit bidirectional data port. The port is split into four 9-bit byte lanes, and the highest bit of each lane is its parity bit. Every cycle, the block checks the parity of each lane on the incoming bus. It reports a failure on an active-low error flag, which is registered on the port clock. When the port reads, the outgoing word comes either from the FIFO path or from the mailbox path. If generation is enabled, each lane's top bit is replaced with freshly computed parity. One odd/even select sets the parity sense for both checking and generation.

Only one checking tree set exists. A mailbox read with generation enabled borrows that tree set to compute the mailbox word's parity. While the trees are borrowed, they cannot check the bus, so the error flag is held inactive. A small two-state controller records who owns the trees: `TREE_CHECK` means the trees check the bus, and `TREE_LENT` means they serve the mailbox. The controller moves to `TREE_LENT` on every clock edge where a lend is requested and back to `TREE_CHECK` on every edge where no lend is requested. The flag is driven from that state and from the registered lane-failure result. FIFO reads use a dedicated generator tree and never borrow.

Top module: `bpar_top`

## Requirements
- R1: Lane k holds bits 9k to 9k+8 of the word, for k = 0 to 3. Bit 9k+8 is that lane's parity bit and the lower eight bits are its data.
- R2: With `odd_sel` = 1, a lane passes when the XOR of its nine bits is 1. With `odd_sel` = 0, it passes when that XOR is 0.
- R3: When no lend is requested, `perr_n` after a rising clock edge is 0 if any lane of `bus_in` sampled at that edge failed, and 1 if all four passed.
- R4: On a read (`dir_wr` = 0) with `gen_en` = 1, `bus_out` bit 9k+8 equals the generated parity of the lane's eight data bits under the current sense, and all other bits equal the selected source word.
- R5: On a read with `gen_en` = 0, `bus_out` equals the selected source word unchanged, including its top lane bits.
- R6: On a read, the source word is `mbox_word` when `mbox_sel` = 1 and `rd_word` when `mbox_sel` = 0.
- R7: A lend is a read with `mbox_sel` = 1 and `gen_en` = 1. After a rising edge that samples a lend, `perr_n` is 1 whatever `bus_in` carries.
- R8: While `rst_n` is low at a rising edge, `perr_n` becomes 1 and the controller returns to `TREE_CHECK`.
- R9: With `dir_wr` = 1 (a write), `bus_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| dir_wr | input | 1 | 1 means write (bus drives in), 0 means read |
| mbox_sel | input | 1 | On a read, selects the mailbox word as the source |
| gen_en | input | 1 | Enables parity generation on reads |
| bus_in | input | 36 | Word arriving from the port pads |
| rd_word | input | 36 | Word read from the FIFO path |
| mbox_word | input | 36 | Word read from the mailbox path |
| bus_out | output | 36 | Word sent toward the pads on a read |
| perr_n | output | 1 | Registered active-low parity error flag |

## Verification
The two functions that can land in the same cycle are bus checking and mailbox parity generation, because both need the single shared tree set. The bench provokes the clash by driving a mailbox read with generation enabled while `bus_in` carries a word with a broken lane in each position, under both parity senses. It also does this at random among ordinary traffic. A correct result has two parts. After the edge, the flag must read high even though the bus word is bad. In the same cycle, `bus_out` must carry correctly generated parity for the mailbox word. The cycle that follows a lend must show a bad bus word being flagged again.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    typedef enum logic [0:0] {
        TREE_CHECK = 1'b0,
        TREE_LENT  = 1'b1
    } tree_state_e;

endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] word,
    output logic [LANES-1:0]        data_x
);
    localparam int DATA_W = LANE_W - 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign data_x[k] = ^word[k*LANE_W +: DATA_W];
    end
endmodule

// File: rtl/bpar_fmt.sv
module bpar_fmt #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    dir_wr,
    input  logic                    gen_en,
    input  logic                    odd_sel,
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [LANES-1:0]        data_x,
    output logic [LANES*LANE_W-1:0] bus_out
);
    localparam int DATA_W = LANE_W - 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic top;
        always_comb begin
            top = gen_en ? (data_x[k] ^ odd_sel) : src[k*LANE_W + DATA_W];
        end
        assign bus_out[k*LANE_W +: DATA_W] = dir_wr ? '0 : src[k*LANE_W +: DATA_W];
        assign bus_out[k*LANE_W + DATA_W]  = dir_wr ? 1'b0 : top;
    end
endmodule

// File: rtl/bpar_ctrl.sv
module bpar_ctrl
    import bpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lend_req,
    input  logic any_fail,
    output logic perr_n
);
    tree_state_e state_q, state_d;
    logic        fail_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TREE_CHECK: if (lend_req)  state_d = TREE_LENT;
            TREE_LENT:  if (!lend_req) state_d = TREE_CHECK;
            default:    state_d = TREE_CHECK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TREE_CHECK;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fail_q  <= any_fail;
        end
    end

    always_comb begin
        unique case (state_q)
            TREE_CHECK: perr_n = !fail_q;
            TREE_LENT:  perr_n = 1'b1;
            default:    perr_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/bpar_top.sv
module bpar_top #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    odd_sel,
    input  logic                    dir_wr,
    input  logic                    mbox_sel,
    input  logic                    gen_en,
    input  logic [LANES*LANE_W-1:0] bus_in,
    input  logic [LANES*LANE_W-1:0] rd_word,
    input  logic [LANES*LANE_W-1:0] mbox_word,
    output logic [LANES*LANE_W-1:0] bus_out,
    output logic                    perr_n
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int DATA_W = LANE_W - 1;

    logic              lend;
    logic [WORD_W-1:0] tree_in;
    logic [WORD_W-1:0] src;
    logic [LANES-1:0]  shared_x;
    logic [LANES-1:0]  fifo_x;
    logic [LANES-1:0]  gen_x;
    logic [LANES-1:0]  lane_fail;
    logic              any_fail;

    assign lend    = !dir_wr && mbox_sel && gen_en;
    assign tree_in = lend ? mbox_word : bus_in;
    assign src     = mbox_sel ? mbox_word : rd_word;

    bpar_tree #(.LANES(LANES), .LANE_W(LANE_W)) u_shared_tree (
        .word   (tree_in),
        .data_x (shared_x)
    );

    bpar_tree #(.LANES(LANES), .LANE_W(LANE_W)) u_fifo_tree (
        .word   (rd_word),
        .data_x (fifo_x)
    );

    assign gen_x = mbox_sel ? shared_x : fifo_x;

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        assign lane_fail[k] = (shared_x[k] ^ bus_in[k*LANE_W + DATA_W]) != odd_sel;
    end
    assign any_fail = |lane_fail;

    bpar_fmt #(.LANES(LANES), .LANE_W(LANE_W)) u_fmt (
        .dir_wr  (dir_wr),
        .gen_en  (gen_en),
        .odd_sel (odd_sel),
        .src     (src),
        .data_x  (gen_x),
        .bus_out (bus_out)
    );

    bpar_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lend_req (lend),
        .any_fail (any_fail),
        .perr_n   (perr_n)
    );
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    odd_sel,
    input logic                    dir_wr,
    input logic                    mbox_sel,
    input logic                    gen_en,
    input logic [LANES*LANE_W-1:0] bus_in,
    input logic [LANES*LANE_W-1:0] rd_word,
    input logic [LANES*LANE_W-1:0] mbox_word,
    input logic [LANES*LANE_W-1:0] bus_out,
    input logic                    perr_n
);
    localparam int WORD_W = LANES * LANE_W;

    function automatic logic word_ok(input logic [WORD_W-1:0] w, input logic odd);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if ((^w[k*LANE_W +: LANE_W]) != odd) ok = 1'b0;
        end
        return ok;
    endfunction

    logic lend_c;
    assign lend_c = !dir_wr && mbox_sel && gen_en;

    // R3: a failed lane on the bus is flagged after the edge
    p_bad_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lend_c && !word_ok(bus_in, odd_sel)) |=> !perr_n);

    // R3: a clean bus word keeps the flag high
    p_clean_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lend_c && word_ok(bus_in, odd_sel)) |=> perr_n);

    // R7: a lend holds the flag high
    p_lent_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lend_c |=> perr_n);

    // R4: generated words carry correct parity in every lane
    p_gen_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_wr && gen_en) |-> word_ok(bus_out, odd_sel));

    // R5: with generation off, the read word passes through unchanged
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_wr && !gen_en) |-> bus_out == (mbox_sel ? mbox_word : rd_word));

    // R9: a write keeps the output word at zero
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |-> bus_out == '0);
endmodule

bind bpar_top bpar_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/test_bpar_top.sv
module test_bpar_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         odd_sel = 1'b0;
    logic         dir_wr = 1'b1;
    logic         mbox_sel = 1'b0;
    logic         gen_en = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] rd_word = '0;
    logic [W-1:0] mbox_word = '0;
    logic [W-1:0] bus_out;
    logic         perr_n;

    int   total = 0;
    int   bad = 0;
    logic have_prev = 1'b0;
    logic exp_flag = 1'b1;
    bit   done = 1'b0;
    string prev_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    bpar_top i_bpar_top (.*);

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit word_ok(input logic [W-1:0] w, input logic odd);
        for (int k = 0; k < 4; k++) if ((^w[k*9 +: 9]) != odd) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [W-1:0] fix(input logic [W-1:0] w, input logic odd);
        logic [W-1:0] r = w;
        for (int k = 0; k < 4; k++) r[k*9+8] = (^w[k*9 +: 8]) ^ odd;
        return r;
    endfunction

    function automatic logic [W-1:0] exp_bus(input logic dw, input logic ms, input logic ge,
                                             input logic od, input logic [W-1:0] ff,
                                             input logic [W-1:0] mb);
        logic [W-1:0] s;
        if (dw) return '0;
        s = ms ? mb : ff;
        if (ge) s = fix(s, od);
        return s;
    endfunction

    task automatic step(input logic dw, input logic ms, input logic ge, input logic od,
                        input logic [W-1:0] bi, input logic [W-1:0] ff,
                        input logic [W-1:0] mb, input string ftag, input string btag);
        @(negedge clk);
        if (have_prev) chk({prev_tag, " flag"}, {35'd0, perr_n}, {35'd0, exp_flag});
        dir_wr = dw; mbox_sel = ms; gen_en = ge; odd_sel = od;
        bus_in = bi; rd_word = ff; mbox_word = mb;
        #1;
        chk({btag, " bus_out"}, bus_out, exp_bus(dw, ms, ge, od, ff, mb));
        exp_flag  = (!dw && ms && ge) ? 1'b1 : word_ok(bi, od);
        prev_tag  = ftag;
        have_prev = 1'b1;
    endtask

    function automatic logic [W-1:0] rnd36();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] g;
        void'($urandom(32'd4711));
        // R8: reset state of the flag, with a bad bus word present
        bus_in = 36'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset flag", {35'd0, perr_n}, 36'd1);
        chk("R9 write quiet in reset", bus_out, '0);
        rst_n = 1'b1;

        // R1 R2 R3: a single-bit error in each lane, under both senses
        for (int od = 0; od < 2; od++) begin
            for (int k = 0; k < 4; k++) begin
                g = fix(36'h2_468A_CE13 ^ k, od[0]);
                step(1, 0, 0, od[0], g, '0, '0, "R2 good", "R9");
                step(1, 0, 0, od[0], g ^ (36'h1 << (k*9 + 3)), '0, '0, "R1 R3 data bit", "R9");
                step(1, 0, 0, od[0], g ^ (36'h1 << (k*9 + 8)), '0, '0, "R1 R3 top bit", "R9");
            end
        end

        // R7: a lend while the bus is corrupt, then a bad word flagged again
        for (int od = 0; od < 2; od++) begin
            for (int k = 0; k < 4; k++) begin
                g = fix(36'h9_1357_BDF0, od[0]) ^ (36'h1 << (k*9));
                step(0, 1, 1, od[0], g, 36'h5_5555_5555, 36'hA_BCDE_F012,
                     "R7 lent flag", "R4 R6 mbox gen");
                step(1, 0, 0, od[0], g, '0, '0, "R3 after lend", "R9");
            end
        end

        // R5 R6: pass-through from both sources
        step(0, 0, 0, 0, '0, 36'hF_0F0F_0F0F, 36'h1_2345_6789, "R3 clean", "R5 R6 fifo");
        step(0, 1, 0, 1, fix('0, 1), 36'hF_0F0F_0F0F, 36'h1_2345_6789, "R3 clean odd", "R5 R6 mbox");
        step(0, 0, 1, 1, '0, 36'hF_0F0F_0F0F, 36'h1_2345_6789, "R3 fifo gen bad bus", "R4 fifo gen");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic dw, ms, ge, od;
            logic [W-1:0] bi;
            dw = $urandom_range(0, 1); ms = $urandom_range(0, 1);
            ge = $urandom_range(0, 1); od = $urandom_range(0, 1);
            bi = rnd36();
            if ($urandom_range(0, 1)) bi = fix(bi, od);
            step(dw, ms, ge, od, bi, rnd36(), rnd36(), "R3 R7 random", "R4 R5 R6 R9 random");
        end
        step(1, 0, 0, 0, '0, '0, '0, "R3 final", "R9");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule